// File: doc/BRIEF.md
# Model-Specific-Register Intercept Decision Unit

This unit decides whether a guest access to a model-specific register has to be intercepted by the hypervisor. A request carries a 32-bit register index, a flag that says whether the access is a write, and the control bit that enables bitmap filtering. The unit answers with a single exit bit. The answer goes out over a valid/ready handshake.

When filtering is enabled and the index falls inside one of two 8192-entry windows, the unit fetches one byte from an external 4 Kbyte bitmap store. This fetch uses a single-port read interface with one cycle of latency. The unit then returns the selected bit of that byte. In every other case the unit answers "exit" and does not touch the store.

The store holds four 1 Kbyte maps at these byte offsets:

| Offset | Map |
|---|---|
| 0 | reads, low window |
| 1024 | reads, high window |
| 2048 | writes, low window |
| 3072 | writes, high window |

The low window covers indices 0000_0000h to 0000_1FFFh. The high window covers C000_0000h to C000_1FFFh.

The controller is a four-state machine:

- IDLE: the unit is ready for a request.
- FETCH: the one-byte read is issued.
- CAPTURE: the returned byte is sampled.
- RESP: the answer is held until it is taken.

The transitions are:

- IDLE to FETCH on an accepted request that needs a lookup.
- IDLE to RESP on an accepted request that exits without a lookup.
- FETCH to CAPTURE, unconditionally.
- CAPTURE to RESP, unconditionally.
- RESP to IDLE when the response is taken.

Top module: `msr_intercept_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd_en is 0.
- R2: When req_use_bitmap is 0 at acceptance, the response has rsp_exit = 1. It appears in the cycle right after acceptance, and no memory read is issued for that request.
- R3: With req_use_bitmap = 1, an index outside both windows (0000_0000h–0000_1FFFh and C000_0000h–C000_1FFFh) gives rsp_exit = 1 one cycle after acceptance, with no memory read.
- R4: A read in the low window with index n reads byte address n>>3, which lies in the map at offset 0. rsp_exit equals bit (n & 7) of the returned byte, where bit 0 is the LSB.
- R5: A read in the high window reads byte address 1024 + ((n & 1FFFh) >> 3). rsp_exit equals bit (n & 7) of that byte.
- R6: A write uses the write maps. The low window reads byte address 2048 + (n>>3). The high window reads 3072 + ((n & 1FFFh) >> 3). The bit select is the same as for reads.
- R7: For a lookup, mem_rd_en is high for exactly one cycle, the cycle after acceptance. rsp_valid rises three cycles after acceptance.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1, rsp_exit stays unchanged and req_ready stays 0.
- R9: Once the response is taken, the unit returns to idle in the next cycle, with req_ready = 1 and rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_index | input | 32 | Register index |
| req_is_write | input | 1 | 1 = write access, 0 = read access |
| req_use_bitmap | input | 1 | Bitmap filtering enabled |
| rsp_valid | output | 1 | Decision available |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_exit | output | 1 | 1 = access must be intercepted |
| mem_rd_en | output | 1 | Bitmap store read strobe |
| mem_addr | output | 12 | Bitmap store byte address |
| mem_rd_data | input | 8 | Byte returned one cycle after the strobe |

## Verification
A controller stuck in the wrong state shows up at the ports within a few cycles. The response arrives at the wrong latency, or a read strobe appears for a bypassed request. Another symptom is that req_ready fails to return in the cycle after the response is taken.

A wrong window decode or a wrong map offset sends the read to a different byte address, which is visible at once on mem_addr. A wrong bit select returns an exit bit that disagrees with the bench's copy of the bitmap on roughly half of the random lookups.

// File: rtl/msr_icpt_pkg.sv
package msr_icpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_RESP    = 2'd3
    } icpt_state_e;
endpackage

// File: rtl/msr_window_decode.sv
module msr_window_decode #(
    parameter int                IDX_W     = 32,
    parameter int                WIN_BITS  = 13,
    parameter logic [IDX_W-1:0]  LOW_BASE  = '0,
    parameter logic [IDX_W-1:0]  HIGH_BASE = 32'hC000_0000
) (
    input  logic [IDX_W-1:0]    idx,
    output logic                in_low,
    output logic                in_high,
    output logic [WIN_BITS-1:0] offset
);
    localparam int TAG_W = IDX_W - WIN_BITS;
    localparam logic [IDX_W-1:0] BASES [2] = '{LOW_BASE, HIGH_BASE};

    logic [1:0] hit;

    // One tag comparator per window.
    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_win
            localparam logic [IDX_W-1:0] B = BASES[g];
            assign hit[g] = (idx[IDX_W-1:WIN_BITS] == B[IDX_W-1:WIN_BITS]);
        end
    endgenerate

    assign in_low  = hit[0];
    assign in_high = hit[1];
    assign offset  = idx[WIN_BITS-1:0];

    // R3
    window_excl_chk: assert final (!(in_low && in_high) || (TAG_W < 1));
endmodule

// File: rtl/msr_bitmap_addr.sv
module msr_bitmap_addr #(
    parameter int WIN_BITS  = 13,
    parameter int WORD_W    = 8,
    localparam int BYTE_BITS = $clog2(WORD_W),
    localparam int MAP_AW    = WIN_BITS - BYTE_BITS + 2
) (
    input  logic                 is_write,
    input  logic                 is_high,
    input  logic [WIN_BITS-1:0]  offset,
    output logic [MAP_AW-1:0]    byte_addr,
    output logic [BYTE_BITS-1:0] bit_sel
);
    // Map order: read-low, read-high, write-low, write-high.
    assign byte_addr = {is_write, is_high, offset[WIN_BITS-1:BYTE_BITS]};
    assign bit_sel   = offset[BYTE_BITS-1:0];
endmodule

// File: rtl/msr_icpt_ctrl.sv
module msr_icpt_ctrl
    import msr_icpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic need_lookup,
    input  logic rsp_ready,
    input  logic map_bit,
    output logic req_ready,
    output logic accept,
    output logic rsp_valid,
    output logic rsp_exit,
    output logic mem_rd_en
);
    icpt_state_e state_q, state_d;
    logic        exit_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = need_lookup ? ST_FETCH : ST_RESP;
            ST_FETCH:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_RESP;
            ST_RESP:    if (rsp_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_rd_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_FETCH:   mem_rd_en = 1'b1;
            ST_CAPTURE: ;
            ST_RESP:    rsp_valid = 1'b1;
            default:    ;
        endcase
    end

    assign accept = req_ready && req_valid;

    // Decision register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      exit_q <= 1'b0;
        else if (accept && !need_lookup) exit_q <= 1'b1;
        else if (state_q == ST_CAPTURE)  exit_q <= map_bit;
    end

    assign rsp_exit = exit_q;

    // R7
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en && !rsp_valid);

    // R7
    read_to_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 rsp_valid);

    // R8
    hold_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_exit) && !req_ready);

    // R9
    return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready && !rsp_valid);
endmodule

// File: rtl/msr_intercept_unit.sv
module msr_intercept_unit #(
    parameter int                IDX_W     = 32,
    parameter int                WIN_BITS  = 13,
    parameter int                WORD_W    = 8,
    parameter logic [IDX_W-1:0]  LOW_BASE  = '0,
    parameter logic [IDX_W-1:0]  HIGH_BASE = 32'hC000_0000,
    localparam int BYTE_BITS = $clog2(WORD_W),
    localparam int MAP_AW    = WIN_BITS - BYTE_BITS + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_index,
    input  logic              req_is_write,
    input  logic              req_use_bitmap,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_exit,
    output logic              mem_rd_en,
    output logic [MAP_AW-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rd_data
);
    logic                 lo_hit, hi_hit, need_lookup, accept;
    logic [WIN_BITS-1:0]  win_off;
    logic [MAP_AW-1:0]    addr_d, addr_q;
    logic [BYTE_BITS-1:0] bit_d, bit_q;
    logic                 map_bit;

    msr_window_decode #(
        .IDX_W(IDX_W), .WIN_BITS(WIN_BITS),
        .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
    ) u_decode (
        .idx(req_index), .in_low(lo_hit), .in_high(hi_hit), .offset(win_off)
    );

    msr_bitmap_addr #(.WIN_BITS(WIN_BITS), .WORD_W(WORD_W)) u_addr (
        .is_write(req_is_write), .is_high(hi_hit), .offset(win_off),
        .byte_addr(addr_d), .bit_sel(bit_d)
    );

    assign need_lookup = req_use_bitmap && (lo_hit || hi_hit);

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bit_q  <= '0;
        end else if (accept) begin
            addr_q <= addr_d;
            bit_q  <= bit_d;
        end
    end

    assign mem_addr = addr_q;
    assign map_bit  = mem_rd_data[bit_q];

    msr_icpt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .need_lookup(need_lookup), .rsp_ready(rsp_ready), .map_bit(map_bit),
        .req_ready(req_ready), .accept(accept), .rsp_valid(rsp_valid),
        .rsp_exit(rsp_exit), .mem_rd_en(mem_rd_en)
    );

    // R2
    bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_use_bitmap) |=> rsp_valid && rsp_exit && !mem_rd_en);

    // R3
    outside_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lo_hit && !hi_hit) |=> rsp_valid && rsp_exit && !mem_rd_en);

    // R4
    low_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_use_bitmap && lo_hit && !req_is_write) |=>
        mem_rd_en && mem_addr == {2'b00, $past(req_index[WIN_BITS-1:BYTE_BITS])});

    // R5
    high_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_use_bitmap && hi_hit && !req_is_write) |=>
        mem_rd_en && mem_addr == {2'b01, $past(req_index[WIN_BITS-1:BYTE_BITS])});

    // R6
    write_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && need_lookup && req_is_write) |=>
        mem_rd_en && mem_addr[MAP_AW-1]);
endmodule

// File: tb/msr_intercept_unit_bench.sv
module msr_intercept_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_is_write = 1'b0, req_use_bitmap = 1'b0;
    logic [31:0] req_index = '0;
    logic        rsp_ready = 1'b0;
    logic        req_ready, rsp_valid, rsp_exit, mem_rd_en;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rd_data = '0;

    logic [7:0]  bmem [4096];
    int          checks = 0, errors = 0;
    int          rd_count = 0;
    logic [11:0] last_addr = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    msr_intercept_unit u_msr_intercept_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_is_write(req_is_write),
        .req_use_bitmap(req_use_bitmap), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_exit(rsp_exit), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= bmem[mem_addr];

    always @(negedge clk) if (mem_rd_en) begin
        rd_count  <= rd_count + 1;
        last_addr <= mem_addr;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_lo(input logic [31:0] i); return i[31:13] == 19'h0; endfunction
    function automatic bit in_hi(input logic [31:0] i); return i[31:13] == 19'h60000; endfunction

    function automatic bit exp_lookup(input logic [31:0] i, input bit use_bm);
        return use_bm && (in_lo(i) || in_hi(i));
    endfunction

    function automatic logic [11:0] exp_addr(input logic [31:0] i, input bit wr);
        return {wr, in_hi(i), i[12:3]};
    endfunction

    function automatic bit exp_exit(input logic [31:0] i, input bit wr, input bit use_bm);
        logic [7:0] b;
        if (!exp_lookup(i, use_bm)) return 1'b1;
        b = bmem[exp_addr(i, wr)];
        return b[i[2:0]];
    endfunction

    task automatic run_req(input logic [31:0] idx, input bit wr, input bit use_bm,
                           input int hold, input string tag);
        int  lat;
        int  rd0;
        bit  lk;
        bit  ex;
        lk = exp_lookup(idx, use_bm);
        ex = exp_exit(idx, wr, use_bm);
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; req_is_write = wr; req_use_bitmap = use_bm;
        rd0 = rd_count;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " R7 latency"}, lat, lk ? 3 : 1);
        check({tag, " read count"}, rd_count - rd0, lk ? 1 : 0);
        if (lk) check({tag, " address"}, last_addr, exp_addr(idx, wr));
        check({tag, " exit"}, rsp_exit, ex);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R8 hold valid", rsp_valid, 1);
            check("R8 hold exit", rsp_exit, ex);
            check("R8 ready low", req_ready, 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R9 idle ready", req_ready, 1);
        check("R9 valid low", rsp_valid, 0);
    endtask

    function automatic string tag_of(input logic [31:0] i, input bit wr, input bit use_bm);
        if (!use_bm) return "R2";
        if (!in_lo(i) && !in_hi(i)) return "R3";
        if (wr) return "R6";
        return in_lo(i) ? "R4" : "R5";
    endfunction

    task automatic req(input logic [31:0] idx, input bit wr, input bit use_bm, input int hold);
        run_req(idx, wr, use_bm, hold, tag_of(idx, wr, use_bm));
    endtask

    initial begin
        int unsigned seed;
        logic [31:0] idx;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int a = 0; a < 4096; a++) bmem[a] = 8'($urandom);
        bmem[0] = 8'h01;
        bmem[1023] = 8'h80;
        bmem[1024] = 8'hFE;
        bmem[2048] = 8'h00;
        bmem[4095] = 8'h7F;
        repeat (3) @(negedge clk);
        check("R1 ready", req_ready, 1);
        check("R1 valid", rsp_valid, 0);
        check("R1 read", mem_rd_en, 0);
        rst_n = 1'b1;
        // Directed corners.
        req(32'h0000_0000, 0, 1, 0);
        req(32'h0000_1FFF, 0, 1, 2);
        req(32'h0000_2000, 0, 1, 0);
        req(32'hC000_0000, 0, 1, 0);
        req(32'hC000_1FFF, 1, 1, 1);
        req(32'hC000_2000, 1, 1, 0);
        req(32'hBFFF_FFFF, 0, 1, 0);
        req(32'hFFFF_FFFF, 1, 1, 0);
        req(32'h0000_0000, 1, 1, 0);
        req(32'h0000_0005, 0, 0, 1);
        req(32'hC000_0010, 1, 0, 0);
        // Random mix.
        for (int t = 0; t < 400; t++) begin
            case ($urandom % 4)
                0: idx = {19'h0, 13'($urandom)};
                1: idx = {19'h60000, 13'($urandom)};
                2: idx = $urandom;
                default: idx = ($urandom % 2) ? {19'h1, 13'($urandom)} : {19'h5FFFF, 13'($urandom)};
            endcase
            req(idx, 1'($urandom), ($urandom % 8) != 0, $urandom % 3);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule